// File: doc/BRIEF.md
# Wakeup Auto-Reload Timer with Write Handshake

This block is a down-counting wakeup timer that runs on the slow timer clock. While it is enabled, it counts from a programmed reload value down to zero. On the cycle after the count reaches zero it reloads, raises a sticky wakeup flag and emits a one-cycle interrupt pulse. A reload value of N therefore produces one wakeup every N+1 clock cycles. Disabling the timer freezes the count. Enabling it again restarts the count from the reload value.

The enable level comes from another domain and crosses into the timer domain through a two-stage synchronizer. A write-allowed status tracks the synchronized enable, inverted. The reload value can be changed only while the enable level is low and write-allowed is high; any other reload write is dropped. Software clears the wakeup flag by writing 0 to it. A set from the timer beats a clear that arrives in the same cycle, which is why software has to clear the flag well ahead of the next wakeup.

Top module: `wake_reload_timer`

## Requirements
- R1: After reset, `wr_ok_o`=1, `wake_flag_o`=0, `wake_irq_o`=0, `count_o`=0 and `reload_o` holds the parameter `RELOAD_RST` (default 16'hFFFF).
- R2: `wr_ok_o` falls exactly two clock edges after `run_req_i` goes high, and rises exactly two clock edges after it goes low.
- R3: A reload write (`rld_we_i`=1) updates `reload_o` at the next edge only when `run_req_i`=0 and `wr_ok_o`=1. Any other reload write leaves `reload_o` unchanged.
- R4: One edge after the synchronized enable first reads high, `count_o` equals `reload_o`.
- R5: While enabled, `count_o` drops by one per cycle. At zero it reloads at the next edge, so a reload value N gives one wakeup every N+1 cycles (N=0 gives a wakeup every cycle).
- R6: At the edge where a count of zero reloads, `wake_flag_o` becomes 1 and `wake_irq_o` is high for that one cycle only, unless the next edge is another wakeup.
- R7: Writing 0 to the flag (`flag_we_i`=1, `flag_data_i`=0) clears `wake_flag_o` at the next edge. Writing 1 has no effect.
- R8: If a clear write and a wakeup fall on the same edge, the flag ends up at 1.
- R9: Once the synchronized enable reads low, `count_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_req_i | input | 1 | Enable level, asynchronous to the timer clock |
| rld_we_i | input | 1 | Reload write strobe |
| rld_data_i | input | CNT_W | Reload write data |
| flag_we_i | input | 1 | Flag write strobe |
| flag_data_i | input | 1 | Flag write data; 0 clears |
| wr_ok_o | output | 1 | Reload may be written |
| wake_flag_o | output | 1 | Sticky wakeup flag |
| wake_irq_o | output | 1 | One-cycle wakeup pulse |
| count_o | output | CNT_W | Current count |
| reload_o | output | CNT_W | Current reload value |

## Verification
Most internal faults show up at the ports within one wakeup period. A wrong step or a missed reload shifts `count_o` on the very next cycle and moves every later interrupt pulse. A broken synchronizer depth moves the `wr_ok_o` edge and the first loaded count by one cycle. A gate that lets a reload write through while the timer runs changes `reload_o` one edge after the write, and then changes the period of every later wakeup.

// File: rtl/wkt_pkg.sv
package wkt_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_DEC  = 2'd2,
    ACT_WRAP = 2'd3
  } cnt_act_e;

  // Chooses what the counter does at the coming edge.
  function automatic cnt_act_e pick_action(input logic run_now,
                                           input logic run_prev,
                                           input logic at_zero);
    if (!run_now)      return ACT_HOLD;
    else if (!run_prev) return ACT_LOAD;
    else if (at_zero)   return ACT_WRAP;
    else                return ACT_DEC;
  endfunction

endpackage

// File: rtl/wkt_sync.sv
module wkt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic first_o,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        chain_q[g] <= 1'b0;
      else if (g == 0)
        chain_q[g] <= d_i;
      else
        chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
    end
  end

  assign first_o = chain_q[0];
  assign q_o     = chain_q[STAGES-1];
endmodule

// File: rtl/wkt_counter.sv
module wkt_counter
  import wkt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_s_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             hit_o
);
  logic             run_d_q;
  logic [CNT_W-1:0] cnt_q;
  cnt_act_e         act;

  assign act     = pick_action(run_s_i, run_d_q, cnt_q == '0);
  assign hit_o   = (act == ACT_WRAP);
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_d_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      run_d_q <= run_s_i;
      case (act)
        ACT_LOAD, ACT_WRAP: cnt_q <= reload_i;
        ACT_DEC:            cnt_q <= cnt_q - 1'b1;
        default:            cnt_q <= cnt_q;
      endcase
    end
  end

  a_r4_load_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_s_i && !run_d_q) |=> (cnt_q == $past(reload_i)));
  a_r5_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_s_i && run_d_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r5_wrap_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_s_i && run_d_q && cnt_q == '0) |=> (cnt_q == $past(reload_i)));
  a_r9_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_s_i |=> $stable(cnt_q));
endmodule

// File: rtl/wkt_flag.sv
module wkt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= hit_i;
      if (hit_i)      flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  a_r6_set_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> (flag_q && irq_q));
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> !irq_q);
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit_i) |=> !flag_q);
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && hit_i) |=> flag_q);
endmodule

// File: rtl/wake_reload_timer.sv
module wake_reload_timer #(
  parameter int              CNT_W       = 16,
  parameter int              SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_req_i,
  input  logic             rld_we_i,
  input  logic [CNT_W-1:0] rld_data_i,
  input  logic             flag_we_i,
  input  logic             flag_data_i,
  output logic             wr_ok_o,
  output logic             wake_flag_o,
  output logic             wake_irq_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] reload_o
);
  logic             run_first, run_s;
  logic             hit;
  logic             rld_take;
  logic             flag_clr;
  logic [CNT_W-1:0] reload_q;

  wkt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (run_req_i),
    .first_o (run_first),
    .q_o     (run_s)
  );

  assign wr_ok_o  = ~run_s;
  assign rld_take = rld_we_i && !run_req_i && wr_ok_o;
  assign flag_clr = flag_we_i && !flag_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       reload_q <= RELOAD_RST;
    else if (rld_take) reload_q <= rld_data_i;
  end
  assign reload_o = reload_q;

  wkt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_s_i  (run_s),
    .reload_i (reload_q),
    .count_o  (count_o),
    .hit_o    (hit)
  );

  wkt_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .clr_i  (flag_clr),
    .flag_o (wake_flag_o),
    .irq_o  (wake_irq_o)
  );

  a_r3_write_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rld_we_i && (run_req_i || !wr_ok_o)) |=> $stable(reload_q));
  a_r3_write_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rld_we_i && !run_req_i && wr_ok_o) |=> (reload_q == $past(rld_data_i)));
  a_r2_falls_after_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_first && wr_ok_o) |=> !wr_ok_o);
  a_r2_rises_after_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_first && !wr_ok_o) |=> wr_ok_o);
endmodule

// File: tb/sim_wake_reload_timer.sv
module sim_wake_reload_timer;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         run_req = 1'b0, rld_we = 1'b0, flag_we = 1'b0, flag_data = 1'b0;
  logic [W-1:0] rld_data = '0;
  logic         wr_ok, wflag, wirq;
  logic [W-1:0] count, reload;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wake_reload_timer #(.CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .run_req_i(run_req),
    .rld_we_i(rld_we), .rld_data_i(rld_data),
    .flag_we_i(flag_we), .flag_data_i(flag_data),
    .wr_ok_o(wr_ok), .wake_flag_o(wflag), .wake_irq_o(wirq),
    .count_o(count), .reload_o(reload)
  );

  // Reference model built from the requirements
  logic [1:0]   m_pipe;      // enable as seen 1 and 2 edges later
  logic         m_seen;      // synchronized enable one edge ago
  logic [W-1:0] m_cnt, m_rld;
  logic         m_flag, m_irq;

  function automatic logic [W-1:0] exp_after(input logic [W-1:0] c, input logic [W-1:0] n);
    return (c == 0) ? n : W'(int'(c) - 1);
  endfunction

  function automatic logic model_hit(input logic en, input logic was, input logic [W-1:0] c);
    return en & was & (c == 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pipe <= 2'b00; m_seen <= 1'b0; m_cnt <= '0; m_rld <= 16'hFFFF;
      m_flag <= 1'b0;  m_irq <= 1'b0;
    end else begin
      m_pipe <= {m_pipe[0], run_req};
      m_seen <= m_pipe[1];
      if (m_pipe[1]) m_cnt <= m_seen ? exp_after(m_cnt, m_rld) : m_rld;
      m_irq <= model_hit(m_pipe[1], m_seen, m_cnt);
      if (model_hit(m_pipe[1], m_seen, m_cnt)) m_flag <= 1'b1;
      else if (flag_we && flag_data == 1'b0) m_flag <= 1'b0;
      if (rld_we && !run_req && !m_pipe[1]) m_rld <= rld_data;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_cmp();
    chk("R2 wr_ok vs model", 32'(wr_ok), 32'(!m_pipe[1]));
    chk("R3 reload vs model", 32'(reload), 32'(m_rld));
    chk("R5 count vs model", 32'(count), 32'(m_cnt));
    chk("R6 irq vs model", 32'(wirq), 32'(m_irq));
    chk("R7 flag vs model", 32'(wflag), 32'(m_flag));
  endtask

  task automatic step();
    @(negedge clk);
    rld_we = 1'b0; flag_we = 1'b0;
  endtask

  initial begin
    int t;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk("R1 wr_ok", 32'(wr_ok), 1);
    chk("R1 flag", 32'(wflag), 0);
    chk("R1 irq", 32'(wirq), 0);
    chk("R1 count", 32'(count), 0);
    chk("R1 reload", 32'(reload), 32'hFFFF);
    rst_n = 1'b1;

    // R3 accepted write while idle
    @(negedge clk); rld_we = 1; rld_data = 16'd4;
    step(); chk("R3 idle write taken", 32'(reload), 4);

    // R2 fall latency, R4 load, R5 countdown, R6 pulse
    run_req = 1;
    step(); chk("R2 wr_ok after 1 edge", 32'(wr_ok), 1);
    step(); chk("R2 wr_ok after 2 edges", 32'(wr_ok), 0);
    step(); chk("R4 loaded", 32'(count), 4);
    for (int k = 3; k >= 0; k--) begin
      step(); chk("R5 countdown", 32'(count), 32'(k));
    end
    step(); chk("R6 irq at wrap", 32'(wirq), 1);
    chk("R6 flag at wrap", 32'(wflag), 1);
    chk("R5 reload at wrap", 32'(count), 4);
    for (int k = 0; k < 4; k++) begin
      step(); chk("R6 irq low between wakeups", 32'(wirq), 0);
    end
    step(); chk("R5 period N+1", 32'(wirq), 1);

    // R3 write while running is dropped
    rld_we = 1; rld_data = 16'd9;
    step(); chk("R3 write while running ignored", 32'(reload), 4);

    // R7 writing 1 does nothing, writing 0 clears (count nonzero -> no wrap)
    flag_we = 1; flag_data = 1;
    step(); chk("R7 write one no effect", 32'(wflag), 1);
    while (count < 2) step();
    flag_we = 1; flag_data = 0;
    step(); chk("R7 clear by zero", 32'(wflag), 0);

    // R2 rise latency, R3 gate on wr_ok, R9 freeze
    run_req = 0;
    rld_we = 1; rld_data = 16'd7;
    step(); chk("R2 wr_ok still low", 32'(wr_ok), 0);
    chk("R3 write before wr_ok ignored", 32'(reload), 4);
    step(); chk("R2 wr_ok high after 2 edges", 32'(wr_ok), 1);
    t = int'(count);
    repeat (5) step();
    chk("R9 count frozen", 32'(count), 32'(t));

    // R5 N=0 and R8 set beats clear
    rld_we = 1; rld_data = 16'd0;
    step(); chk("R3 zero reload taken", 32'(reload), 0);
    run_req = 1;
    repeat (5) step();
    chk("R5 zero reload irq", 32'(wirq), 1);
    step(); chk("R5 zero reload irq every cycle", 32'(wirq), 1);
    flag_we = 1; flag_data = 0;
    step(); chk("R8 set wins over clear", 32'(wflag), 1);
    run_req = 0;
    repeat (4) step();

    // Constrained random against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      model_cmp();
      rld_we = 1'b0; flag_we = 1'b0;
      if ($urandom_range(39) == 0) run_req = ~run_req;
      if ($urandom_range(7) == 0) begin
        rld_we = 1; rld_data = W'($urandom_range(12));
      end
      if ($urandom_range(5) == 0) begin
        flag_we = 1; flag_data = 1'($urandom_range(1));
      end
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule